// File: doc/BRIEF.md
# Page-Splitting Serial Flash Program Sequencer

This block turns a single program request into the command traffic a serial NOR flash needs. A request carries a 24-bit start address, a byte count and a sector count that gives the device size. The data follows on a ready/valid byte stream. Requests that would run past the end of the device are refused before any bus traffic starts. An accepted request begins with a write-enable and a status poll, which lets any earlier operation finish. The data is then written as a series of page-program commands. Each command is cut so that it never crosses a 256-byte page, and each one is wrapped in its own write-enable and a status poll that waits for the program to complete. A write-disable closes the run.

The bit-level serial shifter sits outside the block. The block reaches it through a byte port. It holds a request together with the byte to send and a flag that marks the last byte of a chip-select frame. The shifter answers with a one-cycle acknowledge and the byte it received. On the data side, the sequencer pulls each byte only when the command is ready to carry it. While it waits for a byte it keeps the frame open and sends no byte request.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `spi_req` and `wr_ready` are all low.
- R2: When `start` is seen while idle and `req_addr + req_len` exceeds `req_sectors * 4096`, `done` and `err` are high in the next cycle and `busy` stays low. No byte request is made and no data byte is taken. A sum equal to that product is accepted.
- R3: A request with `req_len == 0` gives `done` high with `err` low in the next cycle, with no byte request and no data taken.
- R4: An accepted request first sends a one-byte frame 0x06, then a status poll, and only then the first chunk.
- R5: Each chunk is `min(remaining, 256 - addr[7:0])` bytes long, so no chunk crosses a 256-byte page. After a chunk the address and the written total advance by that length.
- R6: Each chunk is sent as a one-byte frame 0x06, then one frame holding 0x02, address bits [23:16], [15:8] and [7:0], and then the chunk data in stream order. `spi_last` is high only on the final data byte.
- R7: A status poll is a frame of 0x05 followed by 0xFF with `spi_last` high. If bit 0 of the byte received with the 0xFF is 1, the poll frame is repeated. If it is 0, the poll ends.
- R8: When all bytes are written, a one-byte frame 0x04 is sent. In the cycle after its acknowledge `done` pulses for one cycle with `err` low and `busy` low.
- R9: A data byte is taken when `wr_valid` and `wr_ready` are both high. While `wr_ready` is high, `spi_req` is low.
- R10: Once raised, `spi_req` stays high with `spi_tx` and `spi_last` unchanged until the cycle in which `spi_ack` is seen.
- R11: `busy` is high from the cycle after an accepted request until `done` pulses. `done` never occurs while `busy` is high, and `err` is low while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| req_addr | input | 24 | Start address |
| req_len | input | 16 | Number of bytes to program |
| req_sectors | input | 13 | Device size in 4096-byte sectors, sampled with `start` |
| wr_data | input | 8 | Data stream byte |
| wr_valid | input | 1 | Data stream byte valid |
| wr_ready | output | 1 | Sequencer takes a byte |
| spi_req | output | 1 | Byte transfer request to the shifter |
| spi_tx | output | 8 | Byte to send |
| spi_last | output | 1 | Byte ends the chip-select frame |
| spi_ack | input | 1 | Shifter finished the byte (one cycle) |
| spi_rx | input | 8 | Byte received during the transfer |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was refused for capacity |

## Verification
Two events can fall in the same cycle. The first is the end of a status poll, where the address and the remaining count advance. The second is the decision whether another chunk follows or the write-disable is due. They coincide when a chunk ends exactly on a page boundary or exactly at the end of the data. Directed requests provoke this: a start at offset 0xFF, a full aligned page, a run ending precisely at device capacity, and a multi-page run from mid-page. Random requests with random poll-busy counts and stream stalls are added to these. Every byte the shifter sees is compared, together with its frame-end flag, against a sequence the bench builds from the chunk rule. A wrong advance or a wrong end decision therefore shows up as a misplaced address byte, an extra chunk or a missing 0x04 frame.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_DUMMY = 8'hFF;
    localparam int PAGE_BYTES = 256;
    localparam int SECT_SHIFT = 12;

    typedef enum logic [3:0] {
        S_IDLE, S_WEN0, S_STAT_CMD, S_STAT_RD, S_WEN,
        S_PROG_CMD, S_PROG_ADR, S_DGET, S_DSEND, S_WDIS
    } fps_state_e;

    typedef struct packed {
        logic [7:0] tx;
        logic       last;
        logic       req;
    } fps_byte_t;

    function automatic logic [8:0] page_room(input logic [7:0] lo);
        return 9'(PAGE_BYTES) - {1'b0, lo};
    endfunction
endpackage

// File: rtl/fps_admit.sv
module fps_admit #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int SEC_W  = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SEC_W-1:0]  sectors,
    output logic              is_zero,
    output logic              over_cap
);
    import fps_pkg::*;
    localparam int SUM_W = ADDR_W + 2;
    logic [SUM_W-1:0] sum_w, cap_w;
    always_comb begin
        sum_w    = SUM_W'(addr) + SUM_W'(len);
        cap_w    = SUM_W'(sectors) << SECT_SHIFT;
        is_zero  = (len == '0);
        over_cap = (sum_w > cap_w);
    end
endmodule

// File: rtl/fps_chunk.sv
module fps_chunk #(
    parameter int LEN_W = 16
) (
    input  logic [7:0]       addr_lo,
    input  logic [LEN_W-1:0] remaining,
    output logic [8:0]       chunk
);
    import fps_pkg::*;
    logic [8:0] room;
    always_comb begin
        room  = page_room(addr_lo);
        chunk = (remaining < LEN_W'(room)) ? remaining[8:0] : room;
    end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int SEC_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [SEC_W-1:0]  req_sectors,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              spi_req,
    output logic [7:0]        spi_tx,
    output logic              spi_last,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx,
    output logic              busy,
    output logic              done,
    output logic              err
);
    import fps_pkg::*;

    fps_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [8:0]        chunk_q, cnt_q, chunk_w;
    logic [1:0]        aidx_q;
    logic [7:0]        byte_q;
    logic              first_q, done_q, err_q;
    logic              is_zero, over_cap;
    fps_byte_t         out_w;

    fps_admit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEC_W(SEC_W)) u_admit (
        .addr(req_addr), .len(req_len), .sectors(req_sectors),
        .is_zero(is_zero), .over_cap(over_cap)
    );

    fps_chunk #(.LEN_W(LEN_W)) u_chunk (
        .addr_lo(addr_q[7:0]), .remaining(rem_q), .chunk(chunk_w)
    );

    always_comb begin
        out_w = '{tx: 8'h00, last: 1'b0, req: 1'b1};
        case (state_q)
            S_WEN0, S_WEN: begin out_w.tx = OP_WEN; out_w.last = 1'b1; end
            S_STAT_CMD:    out_w.tx = OP_STAT;
            S_STAT_RD:     begin out_w.tx = OP_DUMMY; out_w.last = 1'b1; end
            S_PROG_CMD:    out_w.tx = OP_PROG;
            S_PROG_ADR: begin
                case (aidx_q)
                    2'd0:    out_w.tx = addr_q[23:16];
                    2'd1:    out_w.tx = addr_q[15:8];
                    default: out_w.tx = addr_q[7:0];
                endcase
            end
            S_DSEND:       begin out_w.tx = byte_q; out_w.last = (cnt_q == 9'd1); end
            S_WDIS:        begin out_w.tx = OP_WDIS; out_w.last = 1'b1; end
            default:       out_w.req = 1'b0;
        endcase
    end

    assign spi_req  = out_w.req;
    assign spi_tx   = out_w.tx;
    assign spi_last = out_w.last;
    assign wr_ready = (state_q == S_DGET);
    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign err      = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            chunk_q <= '0;
            cnt_q   <= '0;
            aidx_q  <= '0;
            byte_q  <= '0;
            first_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    if (is_zero) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b0;
                    end else if (over_cap) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        err_q   <= 1'b0;
                        addr_q  <= req_addr;
                        rem_q   <= req_len;
                        first_q <= 1'b1;
                        state_q <= S_WEN0;
                    end
                end
                S_WEN0:     if (spi_ack) state_q <= S_STAT_CMD;
                S_STAT_CMD: if (spi_ack) state_q <= S_STAT_RD;
                S_STAT_RD: if (spi_ack) begin
                    if (spi_rx[0]) begin
                        state_q <= S_STAT_CMD;
                    end else if (first_q) begin
                        first_q <= 1'b0;
                        state_q <= S_WEN;
                    end else begin
                        addr_q  <= addr_q + ADDR_W'(chunk_q);
                        rem_q   <= rem_q - LEN_W'(chunk_q);
                        state_q <= (rem_q == LEN_W'(chunk_q)) ? S_WDIS : S_WEN;
                    end
                end
                S_WEN: if (spi_ack) begin
                    chunk_q <= chunk_w;
                    state_q <= S_PROG_CMD;
                end
                S_PROG_CMD: if (spi_ack) begin
                    aidx_q  <= 2'd0;
                    state_q <= S_PROG_ADR;
                end
                S_PROG_ADR: if (spi_ack) begin
                    if (aidx_q == 2'd2) begin
                        cnt_q   <= chunk_q;
                        state_q <= S_DGET;
                    end else begin
                        aidx_q <= aidx_q + 2'd1;
                    end
                end
                S_DGET: if (wr_valid) begin
                    byte_q  <= wr_data;
                    state_q <= S_DSEND;
                end
                S_DSEND: if (spi_ack) begin
                    cnt_q   <= cnt_q - 9'd1;
                    state_q <= (cnt_q == 9'd1) ? S_STAT_CMD : S_DGET;
                end
                S_WDIS: if (spi_ack) begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx) && $stable(spi_last)));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11
    err_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !err);

    // R9
    data_excl_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !spi_req);

    // R5
    page_fit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PROG_CMD) |->
            ((({1'b0, addr_q[7:0]} + chunk_q) <= 9'(PAGE_BYTES)) &&
             (chunk_q != 9'd0) && (LEN_W'(chunk_q) <= rem_q)));

    // R2
    reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (!spi_req && !wr_ready));
endmodule

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_prog_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [12:0] req_sectors = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic        spi_req;
    logic [7:0]  spi_tx;
    logic        spi_last;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx = '0;
    logic        busy, done, err;

    always #2.5 clk = ~clk;

    flash_prog_seq u0 (
        .clk(clk), .rst(rst), .start(start), .req_addr(req_addr), .req_len(req_len),
        .req_sectors(req_sectors), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .spi_req(spi_req), .spi_tx(spi_tx), .spi_last(spi_last),
        .spi_ack(spi_ack), .spi_rx(spi_rx), .busy(busy), .done(done), .err(err)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // expected byte stream
    logic [7:0] exp_tx [0:4095];
    logic       exp_last [0:4095];
    logic [7:0] exp_rx [0:4095];
    int         exp_kind [0:4095];
    int exp_n = 0;
    int idx = 0;
    int byte_fails = 0;
    int taken = 0;
    int taken_base = 0;
    int reqcnt = 0;
    int cur_len = 0;
    logic [7:0] pat_seed = 8'h00;
    logic src_on = 1'b0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37) + pat_seed);
    endfunction

    function automatic string kind_tag(input int k);
        case (k)
            4: return "R4";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic push(input logic [7:0] tx, input logic last, input logic [7:0] rx, input int k);
        exp_tx[exp_n] = tx; exp_last[exp_n] = last; exp_rx[exp_n] = rx; exp_kind[exp_n] = k;
        exp_n++;
    endtask

    task automatic push_poll(input int busy_n);
        for (int k = 0; k <= busy_n; k++) begin
            push(8'h05, 1'b0, 8'h00, 7);
            push(8'hFF, 1'b1, (k < busy_n) ? 8'h01 : 8'h00, 7);
        end
    endtask

    task automatic build(input int addr, input int len, input int busy_n);
        int a, rem, ch, di;
        exp_n = 0; a = addr; rem = len; di = 0;
        push(8'h06, 1'b1, 8'h00, 4);
        push_poll(busy_n);
        while (rem > 0) begin
            ch = 256 - (a % 256);              // R5
            if (rem < ch) ch = rem;
            push(8'h06, 1'b1, 8'h00, 6);
            push(8'h02, 1'b0, 8'h00, 6);
            push(8'((a >> 16) & 255), 1'b0, 8'h00, 6);
            push(8'((a >> 8) & 255), 1'b0, 8'h00, 6);
            push(8'(a & 255), 1'b0, 8'h00, 6);
            for (int j = 0; j < ch; j++) begin
                push(pat(di), (j == ch - 1), 8'h00, 6);
                di++;
            end
            push_poll(busy_n);
            a += ch; rem -= ch;
        end
        push(8'h04, 1'b1, 8'h00, 8);
    endtask

    task automatic check(input bit ok, input string tag, input string what, input int got, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    // byte-port responder: compare each byte, acknowledge after a random delay
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            spi_ack = 1'b0;
            if (spi_req && !rst) begin
                if (wait_cnt == 0) begin
                    if (idx >= exp_n) begin
                        byte_fails++;
                        $display("FAIL R8 extra byte %0d: got tx=%h expected none", idx, spi_tx);
                        spi_rx = 8'h00;
                    end else begin
                        if (spi_tx !== exp_tx[idx] || spi_last !== exp_last[idx]) begin
                            byte_fails++;
                            if (byte_fails < 6)
                                $display("FAIL %s byte %0d: got tx=%h last=%b expected tx=%h last=%b",
                                         kind_tag(exp_kind[idx]), idx, spi_tx, spi_last,
                                         exp_tx[idx], exp_last[idx]);
                        end
                        spi_rx = exp_rx[idx];
                    end
                    idx++;
                    spi_ack = 1'b1;
                    wait_cnt = $urandom % 3;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    // data stream source, R9
    initial begin
        int di;
        forever begin
            @(negedge clk);
            di = taken - taken_base;
            wr_valid = src_on && (di < cur_len) && (($urandom % 4) != 0);
            wr_data  = pat(di);
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (wr_valid && wr_ready) taken <= taken + 1;
        if (spi_req) reqcnt <= reqcnt + 1;
    end

    task automatic run_ok(input int addr, input int len, input int sectors, input int busy_n);
        int guard, fb;
        build(addr, len, busy_n);
        fb = byte_fails;
        idx = 0;
        @(negedge clk);
        taken_base = taken; cur_len = len; pat_seed = 8'($urandom); src_on = 1'b1;
        build(addr, len, busy_n);
        start = 1'b1; req_addr = 24'(addr); req_len = 16'(len); req_sectors = 13'(sectors);
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R11", "busy after accept", int'(busy), 1);
        guard = 0;
        while (done !== 1'b1 && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        check(done === 1'b1, "R8", "done pulse", int'(done), 1);
        check(err === 1'b0 && busy === 1'b0, "R8", "err/busy at done", int'({err, busy}), 0);
        check(idx == exp_n, "R6", "bytes on port", idx, exp_n);
        check(byte_fails == fb, "R5", "byte stream mismatches", byte_fails - fb, 0);
        check(taken - taken_base == len, "R9", "data bytes taken", taken - taken_base, len);
        src_on = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R8", "done one cycle", int'(done), 0);
    endtask

    task automatic run_quiet(input int addr, input int len, input int sectors, input bit exp_err, input string tag);
        int r0, t0;
        @(negedge clk);
        exp_n = 0; idx = 0;
        r0 = reqcnt; t0 = taken;
        start = 1'b1; req_addr = 24'(addr); req_len = 16'(len); req_sectors = 13'(sectors);
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, tag, "done next cycle", int'(done), 1);
        check(err === exp_err, tag, "err", int'(err), int'(exp_err));
        check(busy === 1'b0, tag, "busy stays low", int'(busy), 0);
        repeat (6) @(negedge clk);
        check(reqcnt == r0 && taken == t0, tag, "bus/data activity", (reqcnt - r0) + (taken - t0), 0);
    endtask

    initial begin
        int a, l;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check({busy, done, err, spi_req, wr_ready} === 5'b0, "R1", "reset outputs",
              int'({busy, done, err, spi_req, wr_ready}), 0);

        // R3 zero length, also with an address beyond the device
        run_quiet(100, 0, 16, 1'b0, "R3");
        run_quiet(24'h00FFFF, 0, 1, 1'b0, "R3");
        // R2 one byte past capacity, and past capacity by far
        run_quiet(65536 - 9, 10, 16, 1'b1, "R2");
        run_quiet(4000, 200, 1, 1'b1, "R2");

        // directed: crossing at one byte into the page (R5)
        run_ok(24'h0001FF, 3, 16, 1);
        // full aligned page, single chunk (R6)
        run_ok(24'h000300, 256, 16, 0);
        // mid-page multi-page run (R5, R7 repeated polls)
        run_ok(24'h000480, 512, 16, 2);
        // ends exactly at capacity, accepted (R2 boundary)
        run_ok(65536 - 10, 10, 16, 1);
        // high address bytes in a large device (R6)
        run_ok(24'hABCDF0, 40, 4096, 0);
        // err cleared by a following good request (R11)
        run_quiet(10, 5000, 1, 1'b1, "R2");
        run_ok(24'h000010, 1, 1, 0);

        // random requests (R4..R9)
        for (int i = 0; i < 12; i++) begin
            a = $urandom % 60000;
            l = 1 + ($urandom % 600);
            run_ok(a, l, 16, $urandom % 3);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        wait (cycles >= 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule